// File: doc/BRIEF.md
# Two-Level Address Translation Lookup Engine

This block answers one question for a translation buffer: which stored entry, if any, translates a given virtual address for the current address-space identifier (ASID). The entries sit in two structures. The first is a set-associative array. All of its entries share one page size, which comes from a global input. The second is a small fully-associative array in which every entry carries its own page size. Each entry covers a pair of adjacent pages. Its tag is virtual address bits 47..13, and only the bits above the pair boundary take part in the comparison.

A lookup starts with a single-cycle strobe that carries the address and the ASID. The engine then probes one location per clock. It tries every way of the selected set first and the fully-associative slots after them, and it stops at the first match. It ends with a one-cycle done pulse, a hit flag and a unified entry index. A write port fills an entry and marks it present. A flush port clears the presence bits, either across one set or across the whole fully-associative array.

Top module: `hyb_tlb_lookup`

## Requirements
- R1: After reset no entry is present, `lk_done` is low, and every lookup reports a miss.
- R2: An entry matches only when three conditions hold: it is present; its global bit is 1 or its stored ASID equals `lk_asid`; and `lk_va[47:ps+1]` equals the same bits of `{tag,13'b0}`, where ps is the entry's page size. Both pages of a pair match one entry.
- R3: A set-associative entry uses `glb_ps`, sampled when the lookup is accepted. The probed set is `(lk_va >> (glb_ps+1)) & 255`. A hit in way w reports index `w*256 + set`.
- R4: Fully-associative slot n has index `2048 + n` and is compared using its own stored page size.
- R5: All 8 set-associative ways are probed, in ascending way order, before fully-associative slots 0..15, also in ascending order. The first match wins.
- R6: If the k-th probe (counted from 1) hits, `lk_done` rises k clock edges after the edge that accepts `lk_start`. A full miss takes 24 edges and reports `lk_hit=0` with `lk_idx=0`.
- R7: A write to an index below 2064 stores the tag, ASID and global bit and marks the entry present. `wr_ps` is stored only for fully-associative indices and is ignored for set-associative ones.
- R8: A flush at an index below 2048 clears the presence bit of all 8 ways of set `fl_idx & 255`.
- R9: A flush at any index from 2048 to 2063 clears every fully-associative slot.
- R10: A flush at an index of 2064 or above changes nothing. A `lk_start` that arrives while a lookup is in progress is ignored.
- R11: `lk_done` is high for exactly one cycle per accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_ps | input | 6 | Page size (log2 bytes) of set-associative entries |
| lk_start | input | 1 | Lookup request strobe |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 10 | Current ASID |
| lk_done | output | 1 | Lookup finished (one cycle) |
| lk_hit | output | 1 | A matching entry was found |
| lk_idx | output | 12 | Unified index of the matching entry |
| wr_en | input | 1 | Fill strobe |
| wr_idx | input | 12 | Unified index to fill |
| wr_tag | input | 35 | Virtual address bits 47..13 of the page pair |
| wr_asid | input | 10 | ASID stored with the entry |
| wr_glob | input | 1 | Global bit: match regardless of ASID |
| wr_ps | input | 6 | Page size for fully-associative entries |
| fl_en | input | 1 | Flush strobe |
| fl_idx | input | 12 | Unified index selecting the flush scope |

## Verification
The checker watches, on every cycle, the properties that can be read off the ports alone. It confirms that done is a single pulse ending a busy period. It confirms that a set-associative hit lands in the set derived from the accepted address, that a miss reports index zero, and that every hit index is in range. It also checks that a fully-associative write leaves the slot present and that a fully-associative flush empties the whole array. The rest needs a model of the stored contents, which only the bench's scenarios provide. That covers which entry wins when several match, the ASID and global filtering, per-entry page-size comparison, the exact probe latency, the ignored `wr_ps` on set-associative fills, line flushes, out-of-range flushes, and starts while busy.

// File: rtl/hyb_tlb_pkg.sv
package hyb_tlb_pkg;
  localparam int VA_W     = 48;
  localparam int PAIR_LSB = 13;
  localparam int TAG_W    = VA_W - PAIR_LSB;
  localparam int ASID_W   = 10;
  localparam int PS_W     = 6;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
  } sa_ent_t;

  typedef struct packed {
    sa_ent_t           base;
    logic [PS_W-1:0]   ps;
  } fa_ent_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SA, PH_FA} phase_e;

  // Bits above the page pair must agree between address and tag.
  function automatic logic page_hit(input logic [VA_W-1:0] va,
                                    input logic [TAG_W-1:0] tag,
                                    input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] keep;
    keep = {VA_W{1'b1}} << (int'(ps) + 1);
    return ((va ^ {tag, {PAIR_LSB{1'b0}}}) & keep) == '0;
  endfunction

  function automatic logic owner_ok(input logic glob,
                                    input logic [ASID_W-1:0] ent_asid,
                                    input logic [ASID_W-1:0] cur_asid);
    return glob | (ent_asid == cur_asid);
  endfunction

  function automatic logic [VA_W-1:0] pair_number(input logic [VA_W-1:0] va,
                                                  input logic [PS_W-1:0] ps);
    return va >> (int'(ps) + 1);
  endfunction
endpackage

// File: rtl/hyb_tlb_sa_bank.sv
module hyb_tlb_sa_bank
  import hyb_tlb_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 256,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int N     = WAYS * SETS,
  localparam int AW    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  sa_ent_t          wr_ent,
  input  logic             fl_en,
  input  logic [SET_W-1:0] fl_set,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_set,
  output sa_ent_t          rd_ent,
  output logic             rd_exist
);
  sa_ent_t      mem [N];
  logic [N-1:0] exist_q;
  logic [AW-1:0] rd_addr;

  assign rd_addr  = {rd_way, rd_set};
  assign rd_ent   = mem[rd_addr];
  assign rd_exist = exist_q[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exist_q <= '0;
    end else begin
      if (wr_en) exist_q[wr_addr] <= 1'b1;
      if (fl_en) begin
        for (int w = 0; w < WAYS; w++) exist_q[{WAY_W'(w), fl_set}] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hyb_tlb_fa_bank.sv
module hyb_tlb_fa_bank
  import hyb_tlb_pkg::*;
#(
  parameter int FA_N = 16,
  localparam int FA_W = (FA_N > 1) ? $clog2(FA_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [FA_W-1:0] wr_slot,
  input  fa_ent_t         wr_ent,
  input  logic            fl_all,
  input  logic [FA_W-1:0] rd_slot,
  output fa_ent_t         rd_ent,
  output logic            rd_exist,
  output logic [FA_N-1:0] exist_o
);
  fa_ent_t         ent_q [FA_N];
  logic [FA_N-1:0] exist_q;

  assign rd_ent   = ent_q[rd_slot];
  assign rd_exist = exist_q[rd_slot];
  assign exist_o  = exist_q;

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_slot] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exist_q <= '0;
    end else begin
      if (wr_en)  exist_q[wr_slot] <= 1'b1;
      if (fl_all) exist_q <= '0;
    end
  end
endmodule

// File: rtl/hyb_tlb_walker.sv
module hyb_tlb_walker
  import hyb_tlb_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 256,
  parameter int FA_N = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int FA_W  = (FA_N > 1) ? $clog2(FA_N) : 1,
  localparam int SA_N  = WAYS * SETS,
  localparam int IDX_W = $clog2(SA_N + FA_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic [PS_W-1:0]   gps,
  input  sa_ent_t           sa_ent,
  input  logic              sa_exist,
  input  fa_ent_t           fa_ent,
  input  logic              fa_exist,
  output logic [WAY_W-1:0]  sa_way,
  output logic [SET_W-1:0]  sa_set,
  output logic [FA_W-1:0]   fa_slot,
  output logic              busy,
  output logic              probe_hit,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  phase_e            phase_q;
  logic [WAY_W-1:0]  way_q;
  logic [FA_W-1:0]   slot_q;
  logic [SET_W-1:0]  set_q;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic [PS_W-1:0]   ps_q;
  logic [VA_W-1:0]   start_pair;
  logic              sa_probe_hit, fa_probe_hit;

  assign start_pair = pair_number(va, gps);
  assign sa_probe_hit = sa_exist && owner_ok(sa_ent.glob, sa_ent.asid, asid_q)
                        && page_hit(va_q, sa_ent.tag, ps_q);
  assign fa_probe_hit = fa_exist && owner_ok(fa_ent.base.glob, fa_ent.base.asid, asid_q)
                        && page_hit(va_q, fa_ent.base.tag, fa_ent.ps);
  assign probe_hit = (phase_q == PH_SA) ? sa_probe_hit :
                     (phase_q == PH_FA) ? fa_probe_hit : 1'b0;
  assign busy    = (phase_q != PH_IDLE);
  assign sa_way  = way_q;
  assign sa_set  = set_q;
  assign fa_slot = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      way_q   <= '0;
      slot_q  <= '0;
      set_q   <= '0;
      va_q    <= '0;
      asid_q  <= '0;
      ps_q    <= '0;
      done    <= 1'b0;
      hit     <= 1'b0;
      idx     <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SA;
          way_q   <= '0;
          va_q    <= va;
          asid_q  <= asid;
          ps_q    <= gps;
          set_q   <= start_pair[SET_W-1:0];
        end
        PH_SA: begin
          if (sa_probe_hit) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
            hit     <= 1'b1;
            idx     <= IDX_W'({way_q, set_q});
          end else if (way_q == WAY_W'(WAYS - 1)) begin
            phase_q <= PH_FA;
            slot_q  <= '0;
          end else begin
            way_q <= way_q + 1'b1;
          end
        end
        PH_FA: begin
          if (fa_probe_hit || slot_q == FA_W'(FA_N - 1)) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
            hit     <= fa_probe_hit;
            idx     <= fa_probe_hit ? IDX_W'(SA_N) + IDX_W'(slot_q) : '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hyb_tlb_lookup.sv
module hyb_tlb_lookup
  import hyb_tlb_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 256,
  parameter int FA_N = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int FA_W  = (FA_N > 1) ? $clog2(FA_N) : 1,
  localparam int SA_N  = WAYS * SETS,
  localparam int SA_AW = $clog2(SA_N),
  localparam int TOTAL = SA_N + FA_N,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PS_W-1:0]   glb_ps,
  input  logic              lk_start,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_idx
);
  logic             wr_in_sa, wr_in_fa, fl_in_sa, fl_in_fa;
  logic [IDX_W-1:0] wr_fa_off;
  sa_ent_t          new_sa;
  fa_ent_t          new_fa;
  logic [WAY_W-1:0] sa_way;
  logic [SET_W-1:0] sa_set;
  logic [FA_W-1:0]  fa_slot;
  sa_ent_t          sa_ent;
  fa_ent_t          fa_ent;
  logic             sa_exist, fa_exist_rd, busy, probe_hit;
  logic [FA_N-1:0]  fa_exist;

  assign wr_in_sa  = wr_en && (wr_idx < IDX_W'(SA_N));
  assign wr_in_fa  = wr_en && !wr_in_sa && (wr_idx < IDX_W'(TOTAL));
  assign fl_in_sa  = fl_en && (fl_idx < IDX_W'(SA_N));
  assign fl_in_fa  = fl_en && !fl_in_sa && (fl_idx < IDX_W'(TOTAL));
  assign wr_fa_off = wr_idx - IDX_W'(SA_N);
  assign new_sa    = '{tag: wr_tag, asid: wr_asid, glob: wr_glob};
  assign new_fa    = '{base: new_sa, ps: wr_ps};

  hyb_tlb_sa_bank #(.WAYS(WAYS), .SETS(SETS)) sa_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_in_sa), .wr_addr(wr_idx[SA_AW-1:0]), .wr_ent(new_sa),
    .fl_en(fl_in_sa), .fl_set(fl_idx[SET_W-1:0]),
    .rd_way(sa_way), .rd_set(sa_set), .rd_ent(sa_ent), .rd_exist(sa_exist)
  );

  hyb_tlb_fa_bank #(.FA_N(FA_N)) fa_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_in_fa), .wr_slot(wr_fa_off[FA_W-1:0]), .wr_ent(new_fa),
    .fl_all(fl_in_fa),
    .rd_slot(fa_slot), .rd_ent(fa_ent), .rd_exist(fa_exist_rd),
    .exist_o(fa_exist)
  );

  hyb_tlb_walker #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) walk_i (
    .clk(clk), .rst_n(rst_n),
    .start(lk_start), .va(lk_va), .asid(lk_asid), .gps(glb_ps),
    .sa_ent(sa_ent), .sa_exist(sa_exist), .fa_ent(fa_ent), .fa_exist(fa_exist_rd),
    .sa_way(sa_way), .sa_set(sa_set), .fa_slot(fa_slot),
    .busy(busy), .probe_hit(probe_hit),
    .done(lk_done), .hit(lk_hit), .idx(lk_idx)
  );
endmodule

// File: rtl/hyb_tlb_lookup_chk.sv
module hyb_tlb_lookup_chk
  import hyb_tlb_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 256,
  parameter int FA_N = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int FA_W  = (FA_N > 1) ? $clog2(FA_N) : 1,
  localparam int SA_N  = WAYS * SETS,
  localparam int TOTAL = SA_N + FA_N,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PS_W-1:0]   glb_ps,
  input logic              lk_start,
  input logic [VA_W-1:0]   lk_va,
  input logic              lk_done,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              fl_en,
  input logic [IDX_W-1:0]  fl_idx,
  input logic              busy,
  input logic [FA_N-1:0]   fa_exist
);
  logic [SET_W-1:0] exp_set_q;
  logic [VA_W-1:0]  pair_now;
  logic             fa_wr_only, fa_fl;
  logic [IDX_W-1:0] wr_off;

  assign pair_now   = pair_number(lk_va, glb_ps);
  assign wr_off     = wr_idx - IDX_W'(SA_N);
  assign fa_wr_only = wr_en && !fl_en && (wr_idx >= IDX_W'(SA_N)) && (wr_idx < IDX_W'(TOTAL));
  assign fa_fl      = fl_en && (fl_idx >= IDX_W'(SA_N)) && (fl_idx < IDX_W'(TOTAL));

  always_ff @(posedge clk) begin
    if (!rst_n) exp_set_q <= '0;
    else if (lk_start && !busy) exp_set_q <= pair_now[SET_W-1:0];
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> (!busy && $past(busy))); // R6
  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_idx == '0)); // R6
  AST_SA_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit && lk_idx < IDX_W'(SA_N)) |-> (lk_idx[SET_W-1:0] == exp_set_q)); // R3
  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit) |-> (lk_idx < IDX_W'(TOTAL))); // R4
  AST_FA_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    fa_fl |=> (fa_exist == '0)); // R9
  AST_FA_WRITE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    fa_wr_only |=> fa_exist[$past(wr_off[FA_W-1:0])]); // R7
endmodule

bind hyb_tlb_lookup hyb_tlb_lookup_chk #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .glb_ps(glb_ps), .lk_start(lk_start), .lk_va(lk_va),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
  .wr_en(wr_en), .wr_idx(wr_idx), .fl_en(fl_en), .fl_idx(fl_idx),
  .busy(busy), .fa_exist(fa_exist)
);

// File: tb/hyb_tlb_lookup_tb_top.sv
module hyb_tlb_lookup_tb_top;
  localparam int NSA = 2048;
  localparam int NT  = 2064;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  glb_ps = 6'd12;
  logic        lk_start = 1'b0;
  logic [47:0] lk_va = '0;
  logic [9:0]  lk_asid = '0;
  logic        lk_done, lk_hit;
  logic [11:0] lk_idx;
  logic        wr_en = 1'b0;
  logic [11:0] wr_idx = '0;
  logic [34:0] wr_tag = '0;
  logic [9:0]  wr_asid = '0;
  logic        wr_glob = 1'b0;
  logic [5:0]  wr_ps = '0;
  logic        fl_en = 1'b0;
  logic [11:0] fl_idx = '0;

  always #4 clk = ~clk;

  hyb_tlb_lookup dut_i (.*);

  // reference model state
  bit          m_e [NT];
  logic [34:0] m_tag [NT];
  logic [9:0]  m_asid [NT];
  bit          m_g [NT];
  int          m_ps [NT];
  bit          m_busy = 0;
  int          m_cnt = 0;
  bit          x_done = 0, x_hit = 0, p_hit = 0;
  int          x_idx = 0, p_idx = 0;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  string       cur_req = "R1";
  bit          last_hit;
  int          last_idx;

  function automatic bit mdl_match(int i, logic [47:0] va, logic [9:0] asid, int gps);
    int ps;
    longint unsigned a, t;
    if (!m_e[i]) return 0;
    ps = (i < NSA) ? gps : m_ps[i];
    a = 64'(va) >> (ps + 1);
    t = 64'(m_tag[i]) >> (ps + 1 - 13);
    return (m_g[i] || m_asid[i] == asid) && (a == t);
  endfunction

  function automatic int set_for(logic [47:0] va, int gps);
    return int'((64'(va) >> (gps + 1)) & 64'd255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_e[i]) m_e[i] = 0;
      m_busy = 0; x_done = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      x_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          x_done = 1; x_hit = p_hit; x_idx = p_idx; m_busy = 0;
        end
      end
      if (lk_start && !was_busy) begin
        int s;
        s = set_for(lk_va, glb_ps);
        p_hit = 0; p_idx = 0; m_cnt = 24;
        for (int k = 0; k < 24 && !p_hit; k++) begin
          int i;
          i = (k < 8) ? k * 256 + s : NSA + (k - 8);
          if (mdl_match(i, lk_va, lk_asid, glb_ps)) begin
            p_hit = 1; p_idx = i; m_cnt = k + 1;
          end
        end
        m_busy = 1;
      end
      if (wr_en && wr_idx < NT) begin
        m_e[wr_idx] = 1; m_tag[wr_idx] = wr_tag; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_glob; m_ps[wr_idx] = wr_ps;
      end
      if (fl_en) begin
        if (fl_idx < NSA) begin
          for (int w = 0; w < 8; w++) m_e[w * 256 + fl_idx % 256] = 0;
        end else if (fl_idx < NT) begin
          for (int i = NSA; i < NT; i++) m_e[i] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_cmp++;
      if (lk_done !== x_done) begin
        n_bad++;
        $display("FAIL %s R11: lk_done=%0b expected %0b", cur_req, lk_done, x_done);
      end else if (x_done) begin
        last_hit = lk_hit; last_idx = int'(lk_idx);
        if (lk_hit !== x_hit || int'(lk_idx) != x_idx) begin
          n_bad++;
          $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                   cur_req, lk_hit, lk_idx, x_hit, x_idx);
        end
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(int idx, logic [47:0] va, logic [9:0] asid, bit g, int ps);
    @(negedge clk);
    wr_en = 1; wr_idx = 12'(idx); wr_tag = va[47:13]; wr_asid = asid;
    wr_glob = g; wr_ps = 6'(ps);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fl(int idx);
    @(negedge clk);
    fl_en = 1; fl_idx = 12'(idx);
    @(negedge clk);
    fl_en = 0;
  endtask

  task automatic look(logic [47:0] va, logic [9:0] asid, string req);
    @(negedge clk);
    cur_req = req; lk_va = va; lk_asid = asid; lk_start = 1;
    @(negedge clk);
    lk_start = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_last(bit h, int idx, string req);
    n_cmp++;
    if (last_hit !== h || last_idx != idx) begin
      n_bad++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, last_hit, last_idx, h, idx);
    end
  endtask

  localparam logic [47:0] VA_A = 48'h0000_1234_6000;
  localparam logic [47:0] VA_B = 48'h0000_7F40_0000;
  localparam logic [47:0] VA_C = 48'h0000_0055_8000;

  initial begin
    int sa;
    logic [31:0] lf;
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (lk_done !== 1'b0 || lk_hit !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: done=%0b hit=%0b expected 0 0", lk_done, lk_hit);
      end
    end
    rst_n = 1;
    look(VA_A, 10'd5, "R1");
    expect_last(0, 0, "R1");

    sa = set_for(VA_A, 12);
    wr(3 * 256 + sa, VA_A, 10'd5, 0, 12);
    look(VA_A, 10'd5, "R3");
    expect_last(1, 3 * 256 + sa, "R3");
    look(VA_A | 48'hFFF, 10'd5, "R2");
    expect_last(1, 3 * 256 + sa, "R2");
    look(VA_A ^ 48'h1000, 10'd5, "R2");
    expect_last(1, 3 * 256 + sa, "R2");
    look(VA_A, 10'd6, "R2");
    expect_last(0, 0, "R2");
    look(VA_A ^ (48'h1 << 40), 10'd5, "R2");
    expect_last(0, 0, "R2");

    wr(1 * 256 + sa, VA_A, 10'd77, 1, 12);
    look(VA_A, 10'd5, "R5");
    expect_last(1, 1 * 256 + sa, "R5");
    look(VA_A, 10'd300, "R2");
    expect_last(1, 1 * 256 + sa, "R2");

    wr(NSA + 2, VA_B, 10'd9, 0, 21);
    look(VA_B | 48'h3F_F123, 10'd9, "R4");
    expect_last(1, NSA + 2, "R4");
    look(VA_B ^ (48'h1 << 22), 10'd9, "R4");
    expect_last(0, 0, "R4");
    wr(NSA + 0, VA_A, 10'd5, 0, 12);
    look(VA_A, 10'd5, "R5");
    expect_last(1, 1 * 256 + sa, "R5");
    fl(2 * 256 + sa);
    look(VA_A, 10'd5, "R8");
    expect_last(1, NSA + 0, "R8");

    wr(5 * 256 + set_for(VA_C, 12), VA_C, 10'd1, 0, 21);
    look(VA_C ^ (48'h1 << 21), 10'd1, "R7");
    expect_last(0, 0, "R7");
    look(VA_C, 10'd1, "R7");
    expect_last(1, 5 * 256 + set_for(VA_C, 12), "R7");

    fl(4000);
    look(VA_B, 10'd9, "R10");
    expect_last(1, NSA + 2, "R10");
    fl(NSA + 7);
    look(VA_B, 10'd9, "R9");
    expect_last(0, 0, "R9");

    // start while busy is ignored
    wr(NSA + 4, VA_B, 10'd9, 0, 21);
    @(negedge clk);
    cur_req = "R10"; lk_va = VA_C; lk_asid = 10'd1; lk_start = 1;
    @(negedge clk);
    lk_va = VA_B; lk_asid = 10'd9;
    @(negedge clk);
    lk_start = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    expect_last(1, 5 * 256 + set_for(VA_C, 12), "R10");
    look(VA_B, 10'd9, "R6");
    expect_last(1, NSA + 4, "R6");

    glb_ps = 6'd14;
    wr(6 * 256 + set_for(VA_B, 14), VA_B, 10'd2, 0, 0);
    look(VA_B | 48'h7FFF, 10'd2, "R3");
    expect_last(1, 6 * 256 + set_for(VA_B, 14), "R3");
    glb_ps = 6'd12;

    lf = 32'hACE1_1234;
    for (int k = 0; k < 12; k++) begin
      logic [47:0] va;
      int ps;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      va = {lf[15] ? 16'hFFFF : 16'h0000, lf[31:0]};
      ps = (k % 4 == 0) ? 12 : (k % 4 == 1) ? 14 : (k % 4 == 2) ? 16 : 21;
      wr(NSA + 8 + (k % 8), va, 10'(k), (k % 3) == 0, ps);
      look(va ^ 48'h5, 10'(k), "R4");
      look(va ^ (48'h1 << (ps + 1)), 10'(k), "R2");
      look(va, 10'(k + 1), "R5");
    end

    repeat (4) @(negedge clk);
    summary();
  end
endmodule